// File: doc/BRIEF.md
# Memory Barrier Sequencing Unit

This unit sits between an in-order issue stage and a memory access port. It keeps count of the memory requests that are still in flight and applies three barrier strengths. The ordering barrier holds back younger memory accesses. The completion barrier also freezes all younger execution, and it can wait for pending cache and TLB maintenance. The resynchronisation barrier retires at once and asks the front end to flush every younger instruction and fetch again from a given program counter.

Each read or write that the unit accepts raises two counts: a count of accesses not yet observed and a count of accesses not yet completed. Observation pulses and completion pulses from the memory side lower them. A barrier is accepted only when no other barrier is in flight. It holds its stalls until the cycle in which it retires, and in that cycle it pulses a retire output.

Top module: `mem_barrier_seq`

## Requirements
- R1: After reset, bar_stall, mem_stall, exec_stall, bar_retired and flush are all low.
- R2: An ordering barrier (kind 00) holds mem_stall high from the cycle after acceptance until it retires. It retires as soon as the not-yet-observed counts for its selected access types are zero, even if those accesses have not completed.
- R3: While an ordering barrier is in flight, exec_stall stays low.
- R4: A completion barrier (kind 01, and kind 11, which is treated the same way) holds both mem_stall and exec_stall high. It retires only when both the not-observed and the not-completed counts for its selected types are zero.
- R5: A completion barrier whose option selects both reads and writes also waits until cmo_pending and tlb_pending are both low. With a reads-only or writes-only option, the maintenance flags have no effect on when it retires.
- R6: The option field selects which access types count: 01 means reads only, 10 means writes only, 11 means both, and 00 is treated as both.
- R7: A resynchronisation barrier (kind 10) retires in the first cycle after acceptance and holds exec_stall and mem_stall high during that cycle. flush is high in that same cycle, and restart_pc then equals the bar_next_pc captured at acceptance.
- R8: Only one barrier is in flight at a time. bar_stall is high while one is pending. A bar_valid that arrives then is not accepted and does not change the kind, option or pc held by the pending barrier.
- R9: bar_retired is high for exactly one cycle per barrier. After that cycle all stalls drop.
- R10: Each of the four counts saturates at 15. Further issues at 15 are lost, and a count at zero ignores further pulses that would lower it.
- R11: A memory request accepted in the same cycle as a barrier counts as older than that barrier. Requests presented while mem_stall is high are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_valid | input | 1 | A barrier is presented for issue |
| bar_kind | input | 2 | 00 ordering, 01/11 completion, 10 resynchronisation |
| bar_opt | input | 2 | Access-type option (see R6) |
| bar_next_pc | input | PC_W | Program counter of the instruction after the barrier |
| mem_req_valid | input | 1 | A memory access is presented for issue |
| mem_req_wr | input | 1 | 1 for a write, 0 for a read |
| rd_obs | input | 1 | One earlier read has become observed |
| wr_obs | input | 1 | One earlier write has become observed |
| rd_done | input | 1 | One earlier read has completed |
| wr_done | input | 1 | One earlier write has completed |
| cmo_pending | input | 1 | Cache maintenance still outstanding |
| tlb_pending | input | 1 | TLB maintenance still outstanding |
| bar_stall | output | 1 | Issue stage must hold a further barrier |
| mem_stall | output | 1 | Younger memory accesses are held |
| exec_stall | output | 1 | Younger state-changing execution is held |
| flush | output | 1 | Flush younger instructions and refetch |
| restart_pc | output | PC_W | Refetch address while flush is high |
| bar_retired | output | 1 | Single-cycle barrier retire pulse |

## Verification
The hardest case to reach from the ports is a completion barrier with both reads and writes selected whose earlier accesses are all observed and completed while maintenance is still pending. It also needs to meet saturated counters and barriers that arrive while another one is pending. Directed sequences build each of these cases on purpose: requests are issued in bursts, pulses are timed so that observation runs ahead of completion, and a maintenance flag is held past the last completion. Long seeded random traffic then mixes all kinds and options against a cycle model kept inside the bench.

// File: rtl/mem_barrier_seq.sv
module mem_barrier_seq #(
  parameter int CNT_W = 4,
  parameter int PC_W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bar_valid,
  input  logic [1:0]      bar_kind,
  input  logic [1:0]      bar_opt,
  input  logic [PC_W-1:0] bar_next_pc,
  input  logic            mem_req_valid,
  input  logic            mem_req_wr,
  input  logic            rd_obs,
  input  logic            wr_obs,
  input  logic            rd_done,
  input  logic            wr_done,
  input  logic            cmo_pending,
  input  logic            tlb_pending,
  output logic            bar_stall,
  output logic            mem_stall,
  output logic            exec_stall,
  output logic            flush,
  output logic [PC_W-1:0] restart_pc,
  output logic            bar_retired
);
  localparam logic [1:0] K_ORD = 2'b00;
  localparam logic [1:0] K_RSY = 2'b10;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CZERO = '0;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic up, input logic dn);
    if (up && !dn && c != CMAX) return c + 1'b1;
    if (dn && !up && c != CZERO) return c - 1'b1;
    return c;
  endfunction

  logic            busy;
  logic [1:0]      kind_q, opt_q;
  logic [PC_W-1:0] pc_q;
  logic [CNT_W-1:0] rd_unobs, wr_unobs, rd_out, wr_out;

  wire want_rd = (opt_q != 2'b10);
  wire want_wr = (opt_q != 2'b01);
  wire obs_clear = !(want_rd && rd_unobs != CZERO) && !(want_wr && wr_unobs != CZERO);
  wire cmp_clear = obs_clear && !(want_rd && rd_out != CZERO) && !(want_wr && wr_out != CZERO)
                   && !(want_rd && want_wr && (cmo_pending || tlb_pending));
  wire is_ord = (kind_q == K_ORD);
  wire is_rsy = (kind_q == K_RSY);
  wire retire = busy && (is_ord ? obs_clear : (is_rsy ? 1'b1 : cmp_clear));
  wire accept = bar_valid && !busy;
  wire rd_inc = mem_req_valid && !mem_stall && !mem_req_wr;
  wire wr_inc = mem_req_valid && !mem_stall && mem_req_wr;

  assign bar_stall   = busy;
  assign mem_stall   = busy;
  assign exec_stall  = busy && !is_ord;
  assign bar_retired = retire;
  assign flush       = retire && is_rsy;
  assign restart_pc  = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      kind_q   <= K_ORD;
      opt_q    <= 2'b11;
      pc_q     <= '0;
      rd_unobs <= '0;
      wr_unobs <= '0;
      rd_out   <= '0;
      wr_out   <= '0;
    end else begin
      rd_unobs <= bump(rd_unobs, rd_inc, rd_obs);
      wr_unobs <= bump(wr_unobs, wr_inc, wr_obs);
      rd_out   <= bump(rd_out, rd_inc, rd_done);
      wr_out   <= bump(wr_out, wr_inc, wr_done);
      if (accept) begin
        busy   <= 1'b1;
        kind_q <= bar_kind;
        opt_q  <= bar_opt;
        pc_q   <= bar_next_pc;
      end else if (retire) begin
        busy <= 1'b0;
      end
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bar_retired |=> !bar_retired);

  a_r8_held_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bar_retired) |=> (busy && $stable(kind_q) && $stable(opt_q) && $stable(pc_q)));

  a_r7_resync_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bar_kind == K_RSY) |=> flush);

  a_r4_drained_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_retired && !is_ord && !is_rsy) |-> (!(want_rd && rd_out != CZERO) && !(want_wr && wr_out != CZERO)));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out == CMAX && rd_inc && !rd_done) |=> rd_out == CMAX);

  a_r11_stalled_not_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_stall && !rd_obs && !rd_done && !wr_obs && !wr_done) |=> ($stable(rd_unobs) && $stable(wr_unobs) && $stable(rd_out) && $stable(wr_out)));
endmodule

// File: tb/test_mem_barrier_seq.sv
`timescale 1ns/1ps
module test_mem_barrier_seq;
  localparam int PC_W = 32;
  logic clk = 0, rst_n = 0;
  logic bar_valid = 0, mem_req_valid = 0, mem_req_wr = 0;
  logic [1:0] bar_kind = 0, bar_opt = 0;
  logic [PC_W-1:0] bar_next_pc = 0;
  logic rd_obs = 0, wr_obs = 0, rd_done = 0, wr_done = 0, cmo_pending = 0, tlb_pending = 0;
  logic bar_stall, mem_stall, exec_stall, flush, bar_retired;
  logic [PC_W-1:0] restart_pc;

  always #4 clk = ~clk;

  mem_barrier_seq #(.CNT_W(4), .PC_W(PC_W)) i_mem_barrier_seq (
    .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .bar_kind(bar_kind), .bar_opt(bar_opt),
    .bar_next_pc(bar_next_pc), .mem_req_valid(mem_req_valid), .mem_req_wr(mem_req_wr),
    .rd_obs(rd_obs), .wr_obs(wr_obs), .rd_done(rd_done), .wr_done(wr_done),
    .cmo_pending(cmo_pending), .tlb_pending(tlb_pending), .bar_stall(bar_stall),
    .mem_stall(mem_stall), .exec_stall(exec_stall), .flush(flush), .restart_pc(restart_pc),
    .bar_retired(bar_retired));

  int n_run = 0, n_fail = 0;
  bit m_busy = 0;
  int m_kind = 0, m_opt = 3, m_pc = 0;
  int m_ru = 0, m_wu = 0, m_ro = 0, m_wo = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat(input int c, input bit up, input bit dn);
    if (up && !dn && c != 15) return c + 1;
    if (dn && !up && c != 0) return c - 1;
    return c;
  endfunction

  // R6: 10 = writes only, 01 = reads only, 00/11 = both
  function automatic bit exp_retire();
    bit wr_sel, rd_sel, obs_ok, cmp_ok;
    if (!m_busy) return 0;
    rd_sel = (m_opt != 2);
    wr_sel = (m_opt != 1);
    obs_ok = !(rd_sel && m_ru != 0) && !(wr_sel && m_wu != 0);
    cmp_ok = obs_ok && !(rd_sel && m_ro != 0) && !(wr_sel && m_wo != 0)
             && !(rd_sel && wr_sel && (cmo_pending || tlb_pending));
    if (m_kind == 0) return obs_ok;
    if (m_kind == 2) return 1;
    return cmp_ok;
  endfunction

  task automatic cyc(input string tag);
    bit er, inc_r, inc_w, acc;
    string kt;
    #1;
    er = exp_retire();
    kt = (m_kind == 0) ? "R2" : (m_kind == 2) ? "R7" : "R4/R5";
    check(bar_retired == er, {tag, " ", kt, " R9 retired"}, bar_retired, er);
    check(flush == (er && m_kind == 2), {tag, " R7 flush"}, flush, er && m_kind == 2);
    if (er && m_kind == 2) check(restart_pc == PC_W'(m_pc), {tag, " R7 pc"}, restart_pc, m_pc);
    check(mem_stall == m_busy, {tag, " R2 mem_stall"}, mem_stall, m_busy);
    check(exec_stall == (m_busy && m_kind != 0), {tag, (m_kind == 0) ? " R3" : " R4", " exec_stall"},
          exec_stall, m_busy && m_kind != 0);
    check(bar_stall == m_busy, {tag, " R8 bar_stall"}, bar_stall, m_busy);
    acc = bar_valid && !m_busy;
    inc_r = mem_req_valid && !m_busy && !mem_req_wr;
    inc_w = mem_req_valid && !m_busy && mem_req_wr;
    @(posedge clk);
    m_ru = sat(m_ru, inc_r, rd_obs);
    m_wu = sat(m_wu, inc_w, wr_obs);
    m_ro = sat(m_ro, inc_r, rd_done);
    m_wo = sat(m_wo, inc_w, wr_done);
    if (acc) begin m_busy = 1; m_kind = bar_kind; m_opt = bar_opt; m_pc = bar_next_pc; end
    else if (er) m_busy = 0;
    @(negedge clk);
  endtask

  task automatic idle();
    bar_valid = 0; mem_req_valid = 0; rd_obs = 0; wr_obs = 0; rd_done = 0; wr_done = 0;
  endtask

  task automatic barrier(input int k, input int o, input int pc);
    bar_valid = 1; bar_kind = 2'(k); bar_opt = 2'(o); bar_next_pc = PC_W'(pc);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    check({bar_stall, mem_stall, exec_stall, bar_retired, flush} == 0, "R1 reset", 0, 0);
    @(negedge clk);

    // R2: ordering barrier waits for observation only, not completion
    repeat (3) begin idle(); mem_req_valid = 1; mem_req_wr = 0; cyc("R11 issue"); end
    idle(); barrier(0, 1, 0); cyc("R2 accept");
    idle(); cyc("R2 wait");
    repeat (3) begin idle(); rd_obs = 1; cyc("R2 obs"); end
    idle(); cyc("R2 R3 after");
    repeat (3) begin idle(); rd_done = 1; cyc("R2 drain"); end

    // R5: writes-only completion ignores maintenance
    cmo_pending = 1;
    repeat (2) begin idle(); mem_req_valid = 1; mem_req_wr = 1; cyc("R11 wr"); end
    idle(); barrier(1, 2, 0); cyc("R4 accept");
    repeat (2) begin idle(); wr_obs = 1; cyc("R4 obs"); end
    repeat (2) begin idle(); wr_done = 1; cyc("R4 done"); end
    idle(); cyc("R5 wr-only ignores cmo");

    // R5/R6: option 00 counts as both, waits on maintenance
    idle(); barrier(1, 0, 0); tlb_pending = 1; cyc("R6 accept");
    repeat (3) begin idle(); cyc("R5 hold"); end
    cmo_pending = 0; idle(); cyc("R5 tlb still");
    tlb_pending = 0; idle(); cyc("R5 release");
    idle(); cyc("R9 after");

    // R7 resync and R8 second barrier ignored
    idle(); barrier(2, 3, 32'h1234); cyc("R7 accept");
    idle(); barrier(0, 1, 32'hbeef); #1;
    check(flush && restart_pc == 32'h1234, "R7 direct flush pc", restart_pc, 32'h1234);
    check(exec_stall == 1, "R7 direct exec_stall", exec_stall, 1);
    cyc("R8 blocked");
    idle(); cyc("R8 second now");

    // R10: saturation of counts
    repeat (17) begin idle(); mem_req_valid = 1; mem_req_wr = 0; cyc("R10 fill"); end
    repeat (15) begin idle(); rd_obs = 1; rd_done = 1; cyc("R10 drain"); end
    idle(); barrier(1, 1, 0); cyc("R10 accept");
    idle(); #1;
    check(bar_retired == 1, "R10 saturated count drained", bar_retired, 1);
    cyc("R10 retire");

    // R11: same-cycle request counts as older
    idle(); barrier(0, 2, 0); mem_req_valid = 1; mem_req_wr = 1; cyc("R11 same");
    idle(); #1;
    check(bar_retired == 0, "R11 older write pending", bar_retired, 0);
    cyc("R11 wait");
    idle(); wr_obs = 1; wr_done = 1; cyc("R11 obs");
    idle(); cyc("R11 end");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      idle();
      bar_valid   = ($urandom_range(0, 9) == 0);
      bar_kind    = 2'($urandom_range(0, 3));
      bar_opt     = 2'($urandom_range(0, 3));
      bar_next_pc = $urandom;
      mem_req_valid = ($urandom_range(0, 9) < 4);
      mem_req_wr  = $urandom_range(0, 1) == 1;
      rd_obs  = (m_ru > 0) && ($urandom_range(0, 9) < 3);
      wr_obs  = (m_wu > 0) && ($urandom_range(0, 9) < 3);
      rd_done = (m_ro > 0) && ($urandom_range(0, 9) < 3);
      wr_done = (m_wo > 0) && ($urandom_range(0, 9) < 3);
      if ($urandom_range(0, 19) == 0) cmo_pending = !cmo_pending;
      if ($urandom_range(0, 19) == 0) tlb_pending = !tlb_pending;
      cyc("R2/R4/R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule